// File: doc/BRIEF.md
# Set/Clear Interrupt and DMA Control Block

This block keeps three 16-bit control registers: an interrupt enable mask, an interrupt request latch and a DMA channel control word. Software never rewrites a whole register. Every write carries a mode flag in bit 15. With the flag at 1, each data bit that is 1 sets the matching register bit. With the flag at 0, each data bit that is 1 clears the matching register bit. Data bits that are 0 leave their register bits untouched, so single bits change without a read-modify-write. Each register has a write offset and a separate read offset. An external bus decoder supplies the offset, the write data and a write strobe. Reads are combinational on the same offset.

Hardware event lines set request bits, whatever the state of the enables. From the request and enable registers the block derives a CPU interrupt level, which is the highest level among the pending, enabled sources. From the DMA control word it derives one enable per channel. A master bit gates each output group: bit 14 of the enable register gates the interrupt level, and bit 9 of the DMA word gates every channel.

The block has no sequencing state machine. It is a datapath built from three instances of one set/clear register, a priority encoder and a DMA gate. All registers reset to zero.

Top module: `irq_dma_ctrl`

## Requirements
- R1: After reset every register reads 0x0000, `cpu_ipl` is 0 and `dma_ch_en` is all zero.
- R2: A write with bit 15 = 0 clears each register bit whose data bit is 1 and leaves every other bit unchanged.
- R3: A write with bit 15 = 1 sets each register bit whose data bit is 1 and leaves every other bit unchanged.
- R4: Write offsets are 0 (enable), 1 (request) and 2 (DMA). Read offsets are 4 (enable), 5 (request) and 6 (DMA). Each read offset returns the current register state, with bit 15 always read as 0. Offsets 3 and 7 read as 0x0000.
- R5: Writing 0x7FFF to the enable or request offset clears every bit of that register, including enable bit 14, the interrupt master bit.
- R6: A 1 on `hw_evt[i]` (i in 0..13) sets request bit i on the next clock edge, whatever the enables are. When an event and a clearing write hit the same bit in the same cycle, the event wins.
- R7: `cpu_ipl` is the highest level among the sources whose request and enable bits are both 1. The levels are: bits 0-2 give level 1, bit 3 gives level 2, bits 4-6 give level 3 (bit 5 is the vertical-blank source), bits 7-10 give level 4, bits 11-12 give level 5 and bit 13 gives level 6. With no such source the level is 0.
- R8: `cpu_ipl` is 0 while enable bit 14 is 0.
- R9: `dma_ch_en[i]` (i in 0..8) is 1 exactly when DMA bit i and DMA master bit 9 are both 1. Bit 8 is the bitplane channel, bit 7 the coprocessor channel and bit 6 the blitter channel, so writing 0x83C0 turns on the master and those three channels.
- R10: DMA bits 11 to 14 are unused: writes to them have no effect and they read as 0.
- R11: A write strobe at offset 3, 4, 5, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_off | input | 3 | Register offset from the bus decoder |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for `bus_off` |
| hw_evt | input | 14 | Hardware event lines, one per request bit |
| cpu_ipl | output | 3 | Prioritized CPU interrupt level |
| dma_ch_en | output | 9 | Per-channel DMA enables |

## Verification
The bench applies a clearing write and an event to the same request bit in the same cycle. A design that let the write win would lose an interrupt, and the request readback would show the bit as 0. It mixes enabled and disabled requests of different levels. An encoder that ignored the enable mask, or picked the first rather than the highest source, would report the wrong `cpu_ipl`. It writes 0xFFFF to the DMA word and to unused offsets. A design that stored bits 11 to 14, or that decoded read offsets as writes, would show stray bits on readback. It also drops each master bit while the channel and source bits stay set, and the outputs must then fall to zero.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
    localparam int DATA_W       = 16;
    localparam int OFF_W        = 3;
    localparam int NUM_SRC      = 14;
    localparam int IRQ_MASTER   = 14;
    localparam int NUM_CH       = 9;
    localparam int DMA_MASTER   = 9;
    localparam int DMA_USED     = 11;
    localparam int LVL_W        = 3;

    localparam logic [OFF_W-1:0] OFF_IEN_W = 3'd0;
    localparam logic [OFF_W-1:0] OFF_IRQ_W = 3'd1;
    localparam logic [OFF_W-1:0] OFF_DMA_W = 3'd2;
    localparam logic [OFF_W-1:0] OFF_IEN_R = 3'd4;
    localparam logic [OFF_W-1:0] OFF_IRQ_R = 3'd5;
    localparam logic [OFF_W-1:0] OFF_DMA_R = 3'd6;

    localparam logic [DATA_W-1:0] IEN_MASK = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] IRQ_MASK = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] DMA_MASK = {{(DATA_W-DMA_USED){1'b0}}, {DMA_USED{1'b1}}};

    // Interrupt level carried by each request source bit.
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        if (idx < 3)       return 3'd1;
        else if (idx < 4)  return 3'd2;
        else if (idx < 7)  return 3'd3;
        else if (idx < 11) return 3'd4;
        else if (idx < 13) return 3'd5;
        else               return 3'd6;
    endfunction
endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
    parameter int              W     = 16,
    parameter logic [W-1:0]    WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);
    logic [W-1:0] sel;
    logic [W-1:0] nxt;

    assign sel = wdata & WMASK;

    always_comb begin
        nxt = q;
        if (wr) begin
            if (wdata[W-1]) nxt = q | sel;
            else            nxt = q & ~sel;
        end
        // hardware sets are applied last so they override a same-cycle clear
        nxt = nxt | (hw_set & WMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_dma_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic [NSRC-1:0]  en,
    input  logic [NSRC-1:0]  req,
    input  logic             master,
    output logic [LVL_W-1:0] level
);
    logic [LVL_W-1:0] best;

    always_comb begin
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (en[i] && req[i] && (src_level(i) > best)) best = src_level(i);
        end
        level = master ? best : '0;
    end
endmodule

// File: rtl/dma_gate.sv
module dma_gate #(
    parameter int NCH = 9
) (
    input  logic [NCH-1:0] ctl,
    input  logic           master,
    output logic [NCH-1:0] ch_en
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_en[g] = ctl[g] & master;
    end
endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl
    import irq_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] hw_evt,
    output logic [LVL_W-1:0]  cpu_ipl,
    output logic [NUM_CH-1:0] dma_ch_en
);
    logic [DATA_W-1:0] en_q, req_q, dma_q;
    logic              we_ien, we_irq, we_dma;

    assign we_ien = bus_we && (bus_off == OFF_IEN_W);
    assign we_irq = bus_we && (bus_off == OFF_IRQ_W);
    assign we_dma = bus_we && (bus_off == OFF_DMA_W);

    setclr_reg #(.W(DATA_W), .WMASK(IEN_MASK)) u_ien (
        .clk(clk), .rst_n(rst_n), .wr(we_ien), .wdata(bus_wdata),
        .hw_set('0), .q(en_q)
    );

    setclr_reg #(.W(DATA_W), .WMASK(IRQ_MASK)) u_irq (
        .clk(clk), .rst_n(rst_n), .wr(we_irq), .wdata(bus_wdata),
        .hw_set({{(DATA_W-NUM_SRC){1'b0}}, hw_evt}), .q(req_q)
    );

    setclr_reg #(.W(DATA_W), .WMASK(DMA_MASK)) u_dma (
        .clk(clk), .rst_n(rst_n), .wr(we_dma), .wdata(bus_wdata),
        .hw_set('0), .q(dma_q)
    );

    irq_prio #(.NSRC(NUM_SRC)) u_prio (
        .en(en_q[NUM_SRC-1:0]), .req(req_q[NUM_SRC-1:0]),
        .master(en_q[IRQ_MASTER]), .level(cpu_ipl)
    );

    dma_gate #(.NCH(NUM_CH)) u_gate (
        .ctl(dma_q[NUM_CH-1:0]), .master(dma_q[DMA_MASTER]), .ch_en(dma_ch_en)
    );

    always_comb begin
        case (bus_off)
            OFF_IEN_R: bus_rdata = en_q;
            OFF_IRQ_R: bus_rdata = req_q;
            OFF_DMA_R: bus_rdata = dma_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_dma_ctrl_chk.sv
module irq_dma_ctrl_chk
    import irq_dma_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [OFF_W-1:0]  bus_off,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_SRC-1:0] hw_evt,
    input logic [LVL_W-1:0]  cpu_ipl,
    input logic [NUM_CH-1:0] dma_ch_en,
    input logic [DATA_W-1:0] en_q,
    input logic [DATA_W-1:0] req_q,
    input logic [DATA_W-1:0] dma_q
);
    // R2
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_off == OFF_IRQ_W && !bus_wdata[15]) |=>
        ((req_q[14:0] & $past(bus_wdata[14:0]) & ~$past({1'b0, hw_evt})) == 15'd0));

    // R3
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_off == OFF_IEN_W && bus_wdata[15]) |=>
        ((en_q[14:0] & $past(bus_wdata[14:0])) == $past(bus_wdata[14:0])));

    // R4
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15] == 1'b0);

    // R6
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt != '0) |=> ((req_q[NUM_SRC-1:0] & $past(hw_evt)) == $past(hw_evt)));

    // R8
    irq_master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q[IRQ_MASTER] |-> (cpu_ipl == '0));

    // R9
    dma_master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ch_en != '0) |-> dma_q[DMA_MASTER]);

    // R10
    dma_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off == OFF_DMA_R) |-> (bus_rdata[14:11] == 4'd0));

    // R11
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_off >= 3'd3 && hw_evt == '0) |=>
        ($stable(en_q) && $stable(req_q) && $stable(dma_q)));
endmodule

bind irq_dma_ctrl irq_dma_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
    .cpu_ipl(cpu_ipl), .dma_ch_en(dma_ch_en),
    .en_q(en_q), .req_q(req_q), .dma_q(dma_q)
);

// File: tb/irq_dma_ctrl_tb_top.sv
module irq_dma_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_off = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic [13:0] hw_evt = 14'd0;
    logic [2:0]  cpu_ipl;
    logic [8:0]  dma_ch_en;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_dma_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .hw_evt(hw_evt),
        .cpu_ipl(cpu_ipl), .dma_ch_en(dma_ch_en)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [15:0] d, input logic [13:0] ev);
        @(negedge clk);
        bus_off = off; bus_wdata = d; bus_we = 1'b1; hw_evt = ev;
        @(negedge clk);
        bus_we = 1'b0; hw_evt = '0;
    endtask

    task automatic pulse(input logic [13:0] ev);
        @(negedge clk);
        hw_evt = ev;
        @(negedge clk);
        hw_evt = '0;
    endtask

    task automatic rd(input string tag, input logic [2:0] off, input logic [15:0] exp);
        bus_off = off;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset();
        rd("R1 enable", 3'd4, 16'h0000);
        rd("R1 request", 3'd5, 16'h0000);
        rd("R1 dma", 3'd6, 16'h0000);
        chk("R1 ipl", {13'd0, cpu_ipl}, 16'd0);
        chk("R1 dma_ch_en", {7'd0, dma_ch_en}, 16'd0);
    endtask

    task automatic t_setclr();
        wr(3'd0, 16'h8025, '0);
        rd("R3 set", 3'd4, 16'h0025);
        wr(3'd0, 16'h0004, '0);
        rd("R2 clear", 3'd4, 16'h0021);
        wr(3'd0, 16'h8000, '0);
        rd("R3 empty set", 3'd4, 16'h0021);
        wr(3'd0, 16'h7FFF, '0);
        rd("R5 enable cleared", 3'd4, 16'h0000);
    endtask

    task automatic t_prio();
        wr(3'd0, 16'hC089, '0);
        rd("R4 enable readback", 3'd4, 16'h4089);
        wr(3'd1, 16'h8009, '0);
        chk("R7 level 2", {13'd0, cpu_ipl}, 16'd2);
        wr(3'd1, 16'h8080, '0);
        chk("R7 level 4", {13'd0, cpu_ipl}, 16'd4);
        wr(3'd1, 16'h9000, '0);
        chk("R7 disabled source ignored", {13'd0, cpu_ipl}, 16'd4);
        wr(3'd0, 16'h4000, '0);
        chk("R8 master off", {13'd0, cpu_ipl}, 16'd0);
        rd("R4 request readback", 3'd5, 16'h1089);
        wr(3'd1, 16'h7FFF, '0);
        rd("R5 request cleared", 3'd5, 16'h0000);
        wr(3'd0, 16'h7FFF, '0);
    endtask

    task automatic t_event();
        pulse(14'h0020);
        rd("R6 event with enables off", 3'd5, 16'h0020);
        chk("R8 no level while masked", {13'd0, cpu_ipl}, 16'd0);
        wr(3'd0, 16'hC020, '0);
        chk("R7 vertical blank level 3", {13'd0, cpu_ipl}, 16'd3);
        wr(3'd1, 16'h0028, 14'h0008);
        rd("R6 event beats clear", 3'd5, 16'h0008);
        chk("R7 bit3 not enabled", {13'd0, cpu_ipl}, 16'd0);
        wr(3'd1, 16'h7FFF, '0);
        wr(3'd0, 16'h7FFF, '0);
    endtask

    task automatic t_dma();
        wr(3'd2, 16'h83C0, '0);
        chk("R9 three channels", {7'd0, dma_ch_en}, 16'h01C0);
        rd("R9 dma readback", 3'd6, 16'h03C0);
        wr(3'd2, 16'h0200, '0);
        chk("R9 master off", {7'd0, dma_ch_en}, 16'h0000);
        rd("R9 channel bits kept", 3'd6, 16'h01C0);
        wr(3'd2, 16'hFFFF, '0);
        rd("R10 unused bits", 3'd6, 16'h07FF);
        chk("R9 all channels", {7'd0, dma_ch_en}, 16'h01FF);
        wr(3'd2, 16'h07FF, '0);
        rd("R2 dma cleared", 3'd6, 16'h0000);
    endtask

    task automatic t_bad_off();
        wr(3'd0, 16'h8003, '0);
        wr(3'd4, 16'hFFFF, '0);
        wr(3'd5, 16'hFFFF, '0);
        wr(3'd6, 16'hFFFF, '0);
        wr(3'd3, 16'hFFFF, '0);
        wr(3'd7, 16'hFFFF, '0);
        rd("R11 enable kept", 3'd4, 16'h0003);
        rd("R11 request kept", 3'd5, 16'h0000);
        rd("R11 dma kept", 3'd6, 16'h0000);
        rd("R4 unused offset 3", 3'd3, 16'h0000);
        rd("R4 unused offset 7", 3'd7, 16'h0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setclr();
        t_prio();
        t_event();
        t_dma();
        t_bad_off();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule